// File: doc/BRIEF.md
# Linear sensor drive timing generator

This block produces every digital drive waveform a self-scanning linear photodiode array needs, all from one system clock. It generates two scan clock phases that never overlap, a start pulse that launches each scan, a video line reset pulse tied to the second phase, a global photodiode reset pulse of programmable width, and a one-cycle frame marker for the rest of the chip. All timing is counted in system clock cycles. Four configuration inputs set the phase high time, the gap between phases, the frame length in pixel periods (the integration time) and the width of the global reset.

A pixel period is built from four segments in a fixed order: first phase high, a gap, second phase high, a gap. A frame is a whole number of pixel periods, called slots. The start pulse belongs to slot 0. The configuration is sampled only when a frame begins, so software may rewrite it at any time without producing a broken frame. Any setting that cannot drive the array correctly is clamped. The phase high time is raised to at least 2 cycles. The frame length is raised to at least one full scan, which is the pixel count plus one slot. No data stream passes through the block, so it has no valid/ready interface. Every pin is a plain level.

Top module: `lstg_drive_gen`

## Requirements
- R1: `ph1_o` and `ph2_o` are never high in the same cycle. When the gap is 0, `ph2_o` rises in the same cycle that `ph1_o` falls, giving complementary phases.
- R2: Let H = max(`cfg_half_i`, 2) and G = `cfg_gap_i`. Each phase stays high for exactly H cycles. There are exactly G low cycles between the fall of one phase and the rise of the other. The pixel period is P = 2H + 2G cycles, with `ph1_o` high at offsets 0..H-1 of the slot and `ph2_o` high at offsets H+G..2H+G-1.
- R3: `st_o` is high at frame cycles H+G through 2H+G inclusive, which is H+1 cycles. It therefore rises together with the first `ph2_o` of the frame, and `ph2_o` falls exactly once while `st_o` is high.
- R4: `vrst_o` is `ph2_o` delayed by one cycle. It rises while `ph2_o` is still high and falls in the first cycle after `ph2_o` has gone low.
- R5: A frame lasts F slots, where F = max(`cfg_integ_i`, N_PIX + 1). Consecutive start pulses are therefore F·P cycles apart.
- R6: Let W = `cfg_grst_i`. `grst_o` is high during frame cycles 0..W-1. A value of 0 disables it. The pulse is cut off at the end of the frame, so a W of at least F·P keeps it high for the whole frame.
- R7: `frame_o` is a one-cycle pulse on frame cycle 0, which is the cycle in which `ph1_o` rises.
- R8: The configuration is latched only at the start of a frame. A change applied in the middle of a frame takes effect from the next frame.
- R9: After `run_i` is sampled high from idle, `frame_o` is low at the first clock edge and high after the second. After `run_i` is sampled low, every output is low from the next edge onward.
- R10: While `rst_n` is low, every output is low, whatever `run_i` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Enables waveform generation |
| cfg_half_i | input | CNT_W | Phase high time in cycles (clamped to at least 2) |
| cfg_gap_i | input | CNT_W | Gap between phases in cycles (0 gives complementary phases) |
| cfg_integ_i | input | SLOT_W | Frame length in pixel periods (clamped to at least N_PIX+1) |
| cfg_grst_i | input | GRST_W | Global reset width in cycles (0 disables it) |
| st_o | output | 1 | Start pulse |
| ph1_o | output | 1 | First scan clock phase |
| ph2_o | output | 1 | Second scan clock phase; one pixel per rising edge |
| vrst_o | output | 1 | Video line reset pulse |
| grst_o | output | 1 | Global photodiode reset pulse |
| frame_o | output | 1 | One-cycle frame start marker |

## Verification
The assertions rely on no particular configuration values, because the clamps guarantee a phase high time of at least two cycles and a frame of at least two slots. The one thing they assume is that `run_i` and the configuration are driven synchronously to `clk`. The stimulus draws phase times from 1 to 6, so it exercises the clamp. It draws gaps from 0 to 3, frame lengths on both sides of the minimum, and global reset widths from zero up to longer than a whole frame. Configuration changes are applied at a random point inside a frame, and `run_i` is also dropped in the middle of a frame. Every draw stays small, so that several complete frames fit in the run.

// File: rtl/lstg_pkg.sv
package lstg_pkg;
  // Segment order inside one pixel period (slot)
  typedef enum logic [1:0] {
    SEG_P1 = 2'd0,
    SEG_G1 = 2'd1,
    SEG_P2 = 2'd2,
    SEG_G2 = 2'd3
  } seg_e;
endpackage

// File: rtl/lstg_cfg_latch.sv
module lstg_cfg_latch #(
  parameter int N_PIX  = 128,
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 16,
  parameter int GRST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  cfg_half,
  input  logic [CNT_W-1:0]  cfg_gap,
  input  logic [SLOT_W-1:0] cfg_integ,
  input  logic [GRST_W-1:0] cfg_grst,
  output logic [CNT_W-1:0]  half_q,
  output logic [CNT_W-1:0]  gap_q,
  output logic [SLOT_W-1:0] slots_q,
  output logic [GRST_W-1:0] grst_q
);
  // Two phase cycles so that the delayed reset pulse rises inside phase 2
  localparam logic [CNT_W-1:0]  HALF_MIN = CNT_W'(2);
  // One full scan: start slot plus one slot per pixel
  localparam logic [SLOT_W-1:0] SLOT_MIN = SLOT_W'(N_PIX + 1);

  logic [CNT_W-1:0]  half_cl;
  logic [SLOT_W-1:0] slots_cl;

  always_comb begin
    half_cl  = (cfg_half  < HALF_MIN) ? HALF_MIN : cfg_half;
    slots_cl = (cfg_integ < SLOT_MIN) ? SLOT_MIN : cfg_integ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= HALF_MIN;
      gap_q   <= '0;
      slots_q <= SLOT_MIN;
      grst_q  <= '0;
    end else if (load) begin
      half_q  <= half_cl;
      gap_q   <= cfg_gap;
      slots_q <= slots_cl;
      grst_q  <= cfg_grst;
    end
  end
endmodule

// File: rtl/lstg_scan_seq.sv
module lstg_scan_seq
  import lstg_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int SLOT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CNT_W-1:0]  half,
  input  logic [CNT_W-1:0]  gap,
  input  logic [SLOT_W-1:0] slots,
  output logic              load,
  output logic              ph1_now,
  output logic              ph2_now,
  output logic              slot0_now,
  output logic              first_now
);
  logic              active;
  seg_e              seg;
  logic [CNT_W-1:0]  cnt;
  logic [SLOT_W-1:0] slot;

  logic [CNT_W-1:0]  seg_len;
  logic              seg_last;
  logic              slot_end;
  logic              wrap;
  logic              has_gap;

  always_comb begin
    has_gap  = (gap != '0);
    seg_len  = (seg == SEG_P1 || seg == SEG_P2) ? half : gap;
    seg_last = (cnt == seg_len - CNT_W'(1));
    slot_end = seg_last && ((seg == SEG_G2) || (seg == SEG_P2 && !has_gap));
    wrap     = active && slot_end && (slot == slots - SLOT_W'(1));
    // shadow registers reload when a frame (re)starts
    load     = run && (!active || wrap);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      active <= 1'b0;
      seg    <= SEG_P1;
      cnt    <= '0;
      slot   <= '0;
    end else if (!active) begin
      active <= 1'b1;
      seg    <= SEG_P1;
      cnt    <= '0;
      slot   <= '0;
    end else if (seg_last) begin
      cnt <= '0;
      unique case (seg)
        SEG_P1: seg <= has_gap ? SEG_G1 : SEG_P2;
        SEG_G1: seg <= SEG_P2;
        SEG_P2: seg <= has_gap ? SEG_G2 : SEG_P1;
        SEG_G2: seg <= SEG_P1;
        default: seg <= SEG_P1;
      endcase
      if (slot_end) slot <= wrap ? '0 : slot + SLOT_W'(1);
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    ph1_now   = active && (seg == SEG_P1);
    ph2_now   = active && (seg == SEG_P2);
    slot0_now = (slot == '0);
    first_now = active && (slot == '0) && (seg == SEG_P1) && (cnt == '0);
  end
endmodule

// File: rtl/lstg_wave_out.sv
module lstg_wave_out #(
  parameter int GRST_W  = 16,
  parameter bit GRST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              ph1_now,
  input  logic              ph2_now,
  input  logic              slot0_now,
  input  logic              first_now,
  input  logic [GRST_W-1:0] grst_w,
  output logic              st_q,
  output logic              ph1_q,
  output logic              ph2_q,
  output logic              vrst_q,
  output logic              grst_q,
  output logic              frame_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      st_q    <= 1'b0;
      ph1_q   <= 1'b0;
      ph2_q   <= 1'b0;
      vrst_q  <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      ph1_q   <= ph1_now;
      ph2_q   <= ph2_now;
      // high through slot-0 phase 2 and one cycle after it falls
      st_q    <= (ph2_now && slot0_now) || (st_q && ph2_q);
      vrst_q  <= ph2_q;
      frame_q <= first_now;
    end
  end

  generate
    if (GRST_EN) begin : g_grst
      logic [GRST_W-1:0] grem;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
          grst_q <= 1'b0;
          grem   <= '0;
        end else if (first_now) begin
          grst_q <= (grst_w != '0);
          grem   <= (grst_w != '0) ? grst_w - GRST_W'(1) : '0;
        end else begin
          grst_q <= (grem != '0);
          grem   <= (grem != '0) ? grem - GRST_W'(1) : '0;
        end
      end
    end else begin : g_no_grst
      assign grst_q = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lstg_drive_gen.sv
module lstg_drive_gen #(
  parameter int N_PIX   = 128,
  parameter int CNT_W   = 16,
  parameter int SLOT_W  = 16,
  parameter int GRST_W  = 16,
  parameter bit GRST_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CNT_W-1:0]  cfg_half_i,
  input  logic [CNT_W-1:0]  cfg_gap_i,
  input  logic [SLOT_W-1:0] cfg_integ_i,
  input  logic [GRST_W-1:0] cfg_grst_i,
  output logic              st_o,
  output logic              ph1_o,
  output logic              ph2_o,
  output logic              vrst_o,
  output logic              grst_o,
  output logic              frame_o
);
  logic [CNT_W-1:0]  half_q;
  logic [CNT_W-1:0]  gap_q;
  logic [SLOT_W-1:0] slots_q;
  logic [GRST_W-1:0] grst_w_q;
  logic              load;
  logic              ph1_now;
  logic              ph2_now;
  logic              slot0_now;
  logic              first_now;

  lstg_cfg_latch #(
    .N_PIX (N_PIX),
    .CNT_W (CNT_W),
    .SLOT_W(SLOT_W),
    .GRST_W(GRST_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .cfg_half (cfg_half_i),
    .cfg_gap  (cfg_gap_i),
    .cfg_integ(cfg_integ_i),
    .cfg_grst (cfg_grst_i),
    .half_q   (half_q),
    .gap_q    (gap_q),
    .slots_q  (slots_q),
    .grst_q   (grst_w_q)
  );

  lstg_scan_seq #(
    .CNT_W (CNT_W),
    .SLOT_W(SLOT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_i),
    .half     (half_q),
    .gap      (gap_q),
    .slots    (slots_q),
    .load     (load),
    .ph1_now  (ph1_now),
    .ph2_now  (ph2_now),
    .slot0_now(slot0_now),
    .first_now(first_now)
  );

  lstg_wave_out #(
    .GRST_W (GRST_W),
    .GRST_EN(GRST_EN)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_i),
    .ph1_now  (ph1_now),
    .ph2_now  (ph2_now),
    .slot0_now(slot0_now),
    .first_now(first_now),
    .grst_w   (grst_w_q),
    .st_q     (st_o),
    .ph1_q    (ph1_o),
    .ph2_q    (ph2_o),
    .vrst_q   (vrst_o),
    .grst_q   (grst_o),
    .frame_q  (frame_o)
  );
endmodule

// File: rtl/lstg_drive_chk.sv
module lstg_drive_chk (
  input logic clk,
  input logic rst_n,
  input logic run_i,
  input logic st_o,
  input logic ph1_o,
  input logic ph2_o,
  input logic vrst_o,
  input logic grst_o,
  input logic frame_o
);
  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph1_o && ph2_o));

  p_ph1_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ph1_o) && run_i) |=> (ph1_o || !run_i));

  p_ph2_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ph2_o) && run_i) |=> (ph2_o || !run_i));

  p_st_rises_with_ph2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_o) |-> ph2_o);

  p_st_ends_after_ph2_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st_o) && run_i) |-> (!ph2_o && !$past(ph2_o)));

  p_vrst_rise_in_ph2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vrst_o) |-> ph2_o);

  p_vrst_fall_out_ph2_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vrst_o) |-> !ph2_o);

  p_frame_on_ph1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> (ph1_o && !ph2_o && !st_o));

  p_frame_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o);

  p_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !(st_o || ph1_o || ph2_o || vrst_o || grst_o || frame_o));
endmodule

bind lstg_drive_gen lstg_drive_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .run_i  (run_i),
  .st_o   (st_o),
  .ph1_o  (ph1_o),
  .ph2_o  (ph2_o),
  .vrst_o (vrst_o),
  .grst_o (grst_o),
  .frame_o(frame_o)
);

// File: tb/sim_lstg_drive_gen.sv
module sim_lstg_drive_gen;
  localparam int NP = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [15:0] c_half, c_gap, c_integ, c_grst;
  logic        st_o, ph1_o, ph2_o, vrst_o, grst_o, frame_o;

  always #2 clk = ~clk;  // 250 MHz

  lstg_drive_gen #(.N_PIX(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .cfg_half_i(c_half), .cfg_gap_i(c_gap), .cfg_integ_i(c_integ), .cfg_grst_i(c_grst),
    .st_o(st_o), .ph1_o(ph1_o), .ph2_o(ph2_o), .vrst_o(vrst_o),
    .grst_o(grst_o), .frame_o(frame_o)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int prev_ph2;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_h(int h);
    return (h < 2) ? 2 : h;
  endfunction

  function automatic int eff_f(int f);
    return (f < NP + 1) ? NP + 1 : f;
  endfunction

  task automatic all_low(string req);
    chk(req, "outputs", int'({st_o, ph1_o, ph2_o, vrst_o, grst_o, frame_o}), 0);
  endtask

  // One frame, sampled every negedge from frame cycle 0; optionally reprograms mid-frame
  task automatic check_frame(int h, int g, int f, int w, int chg_at,
                             int nh, int ng, int ni, int nw);
    int p, len;
    p   = 2 * h + 2 * g;
    len = f * p;
    for (int t = 0; t < len; t++) begin
      int o, e1, e2, es, ev, egr, efr;
      o   = t % p;
      e1  = (o < h) ? 1 : 0;
      e2  = (o >= h + g && o < 2 * h + g) ? 1 : 0;
      es  = (t >= h + g && t <= 2 * h + g) ? 1 : 0;
      ev  = prev_ph2;
      egr = (t < w) ? 1 : 0;
      efr = (t == 0) ? 1 : 0;
      chk("R1", "overlap", int'(ph1_o & ph2_o), 0);
      chk("R2", "ph1", int'(ph1_o), e1);
      chk("R2", "ph2", int'(ph2_o), e2);
      chk("R3", "st", int'(st_o), es);
      chk("R4", "vrst", int'(vrst_o), ev);
      chk("R6", "grst", int'(grst_o), egr);
      chk("R7", "frame", int'(frame_o), efr);
      prev_ph2 = e2;
      if (t == chg_at) begin  // R8: new values must wait for the next frame
        c_half = 16'(nh); c_gap = 16'(ng); c_integ = 16'(ni); c_grst = 16'(nw);
      end
      @(negedge clk);
    end
  endtask

  task automatic run_case(int h, int g, int i, int w, int nh, int ng, int ni, int nw,
                          int chg_at, int nfr);
    c_half = 16'(h); c_gap = 16'(g); c_integ = 16'(i); c_grst = 16'(w);
    run = 1'b1;
    @(negedge clk);
    chk("R9", "frame after first edge", int'(frame_o), 0);
    @(negedge clk);
    prev_ph2 = 0;
    // R5: frame length checked by frame_o/st_o landing exactly at the computed cycle
    check_frame(eff_h(h), g, eff_f(i), w, chg_at, nh, ng, ni, nw);
    for (int k = 1; k < nfr; k++)
      check_frame(eff_h(nh), ng, eff_f(ni), nw, -1, nh, ng, ni, nw);
    chk("R5", "next frame start", int'(frame_o), 1);
    run = 1'b0;
    @(negedge clk);
    all_low("R9");
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run = 1'b1;
    c_half = 16'd3; c_gap = 16'd1; c_integ = 16'd0; c_grst = 16'd4;
    repeat (4) @(negedge clk);
    all_low("R10");
    run = 1'b0;
    @(negedge clk);
    all_low("R10");
    rst_n = 1'b1;
    @(negedge clk);
    all_low("R10");

    // complementary phases at minimum width, clamped frame length, no global reset
    run_case(2, 0, 0, 0, 2, 0, 0, 0, -1, 2);
    // phase time below minimum is clamped (R2), gap present
    run_case(1, 2, NP + 1, 5, 1, 2, NP + 1, 5, -1, 2);
    // global reset longer than a whole frame stays high (R6)
    run_case(3, 1, NP + 3, 5000, 3, 1, NP + 3, 5000, -1, 2);
    // mid-frame reprogram (R8), longer integration (R5)
    run_case(2, 1, NP + 4, 7, 5, 0, NP + 9, 30, 40, 3);

    // run dropped in the middle of a frame (R9)
    c_half = 16'd3; c_gap = 16'd2; c_integ = 16'd0; c_grst = 16'd9;
    run = 1'b1;
    repeat (37) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    all_low("R9");
    @(negedge clk);
    all_low("R9");

    for (int r = 0; r < 8; r++) begin
      int h, g, i, w, nh, ng, ni, nw, len0;
      h  = $urandom_range(1, 6); g  = $urandom_range(0, 3);
      i  = $urandom_range(0, NP + 12); w = $urandom_range(0, 60);
      nh = $urandom_range(1, 6); ng = $urandom_range(0, 3);
      ni = $urandom_range(0, NP + 12); nw = $urandom_range(0, 60);
      len0 = eff_f(i) * (2 * eff_h(h) + 2 * g);
      run_case(h, g, i, w, nh, ng, ni, nw, $urandom_range(0, len0 - 1), 2);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule